// File: doc/BRIEF.md
# PHY Initialization Pulse Sequencer

This block runs the synchronization phase that a storage-interface PHY needs before it can be used. Software programs a 32-bit timing-adjust register. That register holds four 4-bit phase lengths and a start bit at position 31. Setting the start bit launches a fixed sequence of phases:

1. A sync-enable pulse.
2. A quiet gap.
3. A sync-reset pulse.
4. A settle wait.
5. A fixed tail of eight extra cycles, which covers the cycles owed to the card bus and the system bus.

When the tail ends, the hardware clears the start bit. Software polls bit 31, or watches the one-cycle done strobe, to learn that the PHY is ready.

Software re-runs the sequence whenever the card clock changes frequency or is stopped and restarted, and whenever the timing or function settings change. All counting is done in the single clock of the block. A phase whose length is programmed as zero takes no cycles at all.

Top module: `phy_sync_sequencer`

## Requirements
- R1: After reset, the register reads 0 and the syncEn, syncRst, busy and done outputs are all low.
- R2: Start condition and readback.
  - A write while idle with bit 31 at 1 starts the sequence in the cycle after the write. From that cycle until completion, busy is high and rdData bit 31 reads 1.
  - A write while idle with bit 31 at 0 only stores the value and starts nothing.
  - Bits 30:16 are plain storage that reads back as written.
  - syncEn and syncRst stay low whenever busy is low.
- R3: syncEn is high for exactly the number of cycles in bits 11:8. It starts in the first busy cycle.
- R4: After syncEn falls, both sync outputs stay low for the number of cycles in bits 7:4. Then syncRst is high for the number of cycles in bits 3:0.
- R5: After syncRst, the sequencer waits the number of cycles in bits 15:12, then 8 more cycles, then clears bit 31. Busy lasts exactly sum of the four fields plus 8 cycles.
- R6: Any phase programmed as zero takes zero cycles. With all four fields at zero, the sequence lasts exactly 8 cycles and neither sync output pulses.
- R7: While busy, every register write is ignored. The register contents and the timing of the running sequence are unchanged.
- R8: Done and output exclusivity.
  - Done is high for exactly the one cycle right after bit 31 clears.
  - syncEn and syncRst are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write value |
| rdData | output | 32 | Current register contents |
| syncEn | output | 1 | Sync-enable pulse to the PHY |
| syncRst | output | 1 | Sync-reset pulse to the PHY |
| busy | output | 1 | Sequence in progress (same as bit 31) |
| done | output | 1 | One-cycle strobe after completion |

## Verification
The assertions check several properties on every cycle:
- the two sync outputs are never high together;
- no sync output is active while the block is idle;
- busy only rises after a start write;
- the duration fields stay frozen while busy;
- done follows the fall of busy;
- at least eight quiet cycles pass after the last sync activity before busy falls.

Exact pulse lengths, the gap position, the total duration and the zero-length skipping can only be shown by the bench. It sweeps every value of each field, compares each output cycle by cycle against the arithmetic schedule, and inserts writes during a run.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int NUM_FIELDS = 4;

  // slot index of each duration nibble inside the register
  localparam int SLOT_RST    = 0;
  localparam int SLOT_GAP    = 1;
  localparam int SLOT_EN     = 2;
  localparam int SLOT_SETTLE = 3;

  // encoding order is the execution order of the phases
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_EN     = 3'd1,
    PH_GAP    = 3'd2,
    PH_RST    = 3'd3,
    PH_SETTLE = 3'd4,
    PH_TAIL   = 3'd5
  } phase_e;

  typedef struct packed {
    logic   loadCnt;
    logic   decCnt;
    logic   clearStart;
    phase_e loadSel;
  } seqStrobe_t;

endpackage

// File: rtl/phy_seq_datapath.sv
module phy_seq_datapath
  import phy_seq_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int FIELD_W     = 4,
  parameter int START_BIT   = 31,
  parameter int TAIL_CYCLES = 8,
  parameter int CNT_W       = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 wrEn,
  input  logic [REG_W-1:0]                     wrData,
  input  seqStrobe_t                           strobe,
  output logic                                 startReq,
  output logic                                 cntZero,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   fieldLen,
  output logic [REG_W-1:0]                     regQ
);

  localparam int FIELDS_W = NUM_FIELDS * FIELD_W;

  logic             regBusy;
  logic             acceptWr;
  logic [REG_W-1:0] fieldSrc;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] selLen;

  assign regBusy  = regQ[START_BIT];
  assign acceptWr = wrEn && !regBusy;
  assign startReq = acceptWr && wrData[START_BIT];

  // on the start edge the lengths come straight from the write data
  assign fieldSrc = startReq ? wrData : regQ;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gFields
    assign fieldLen[g] = fieldSrc[g*FIELD_W +: FIELD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (strobe.clearStart) begin
      regQ[START_BIT] <= 1'b0;
    end else if (acceptWr) begin
      regQ <= wrData;
    end
  end

  always_comb begin
    unique case (strobe.loadSel)
      PH_EN:     selLen = CNT_W'(fieldLen[SLOT_EN]);
      PH_GAP:    selLen = CNT_W'(fieldLen[SLOT_GAP]);
      PH_RST:    selLen = CNT_W'(fieldLen[SLOT_RST]);
      PH_SETTLE: selLen = CNT_W'(fieldLen[SLOT_SETTLE]);
      PH_TAIL:   selLen = CNT_W'(TAIL_CYCLES);
      default:   selLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.loadCnt) begin
      cntQ <= selLen - CNT_W'(1);
    end else if (strobe.decCnt) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign cntZero = (cntQ == '0);

  // upper storage bits are only kept for readback
  logic unusedHigh;
  assign unusedHigh = ^fieldSrc[REG_W-1:FIELDS_W];

endmodule

// File: rtl/phy_seq_control.sv
module phy_seq_control
  import phy_seq_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               startReq,
  input  logic                               cntZero,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fieldLen,
  output seqStrobe_t                         strobe,
  output logic                               syncEn,
  output logic                               syncRst,
  output logic                               done
);

  phase_e     phaseQ;
  phase_e     phaseD;
  logic [3:0] nonZero;
  logic       doneQ;

  // nonZero bit i belongs to phase encoded i+1
  assign nonZero[0] = |fieldLen[SLOT_EN];
  assign nonZero[1] = |fieldLen[SLOT_GAP];
  assign nonZero[2] = |fieldLen[SLOT_RST];
  assign nonZero[3] = |fieldLen[SLOT_SETTLE];

  // first phase at or after 'first' with a nonzero length; the tail always qualifies
  function automatic phase_e pickFrom(input phase_e first, input logic [3:0] nz);
    phase_e r;
    int     startPos;
    r        = PH_TAIL;
    startPos = int'(first) - 1;
    for (int i = 3; i >= 0; i--) begin
      if (i >= startPos && nz[i]) r = phase_e'(3'(i + 1));
    end
    return r;
  endfunction

  always_comb begin
    strobe = '{loadCnt: 1'b0, decCnt: 1'b0, clearStart: 1'b0, loadSel: PH_IDLE};
    phaseD = phaseQ;
    if (phaseQ == PH_IDLE) begin
      if (startReq) begin
        phaseD         = pickFrom(PH_EN, nonZero);
        strobe.loadCnt = 1'b1;
        strobe.loadSel = phaseD;
      end
    end else if (cntZero) begin
      if (phaseQ == PH_TAIL) begin
        phaseD            = PH_IDLE;
        strobe.clearStart = 1'b1;
      end else begin
        phaseD         = pickFrom(phase_e'(3'(phaseQ) + 3'd1), nonZero);
        strobe.loadCnt = 1'b1;
        strobe.loadSel = phaseD;
      end
    end else begin
      strobe.decCnt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      doneQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      doneQ  <= strobe.clearStart;
    end
  end

  assign syncEn  = (phaseQ == PH_EN);
  assign syncRst = (phaseQ == PH_RST);
  assign done    = doneQ;

endmodule

// File: rtl/phy_sync_sequencer.sv
module phy_sync_sequencer
  import phy_seq_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int FIELD_W     = 4,
  parameter int START_BIT   = 31,
  parameter int TAIL_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             syncEn,
  output logic             syncRst,
  output logic             busy,
  output logic             done
);

  localparam int TAIL_W = $clog2(TAIL_CYCLES + 1);
  localparam int CNT_W  = (FIELD_W > TAIL_W) ? FIELD_W : TAIL_W;

  seqStrobe_t                         strobe;
  logic                               startReq;
  logic                               cntZero;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fieldLen;
  logic [REG_W-1:0]                   regQ;

  phy_seq_datapath #(
    .REG_W(REG_W), .FIELD_W(FIELD_W), .START_BIT(START_BIT),
    .TAIL_CYCLES(TAIL_CYCLES), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe), .startReq(startReq), .cntZero(cntZero),
    .fieldLen(fieldLen), .regQ(regQ)
  );

  phy_seq_control #(
    .FIELD_W(FIELD_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cntZero(cntZero),
    .fieldLen(fieldLen), .strobe(strobe), .syncEn(syncEn),
    .syncRst(syncRst), .done(done)
  );

  assign rdData = regQ;
  assign busy   = regQ[START_BIT];

endmodule

// File: rtl/phy_seq_checker.sv
module phy_seq_checker #(
  parameter int FIELDS_W    = 16,
  parameter int TAIL_CYCLES = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                wrStartBit,
  input logic [FIELDS_W-1:0] rdFields,
  input logic                syncEn,
  input logic                syncRst,
  input logic                busy,
  input logic                done
);

  localparam int QW = $clog2(TAIL_CYCLES + 1);

  logic [QW-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) quietCnt <= '0;
    else if (!busy || syncEn || syncRst) quietCnt <= '0;
    else if (quietCnt != QW'(TAIL_CYCLES)) quietCnt <= quietCnt + QW'(1);
  end

  AST_SYNC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(syncEn && syncRst)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!syncEn && !syncRst)); // R2

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn && wrStartBit)); // R2

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdFields)); // R7

  AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy)); // R8

  AST_DONE_FOLLOWS_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R8

  AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(quietCnt) >= QW'(TAIL_CYCLES - 1))); // R5

  AST_EN_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncEn) |-> busy); // R3

endmodule

bind phy_sync_sequencer phy_seq_checker #(
  .FIELDS_W(phy_seq_pkg::NUM_FIELDS * FIELD_W),
  .TAIL_CYCLES(TAIL_CYCLES)
) u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStartBit(wrData[START_BIT]),
  .rdFields(rdData[phy_seq_pkg::NUM_FIELDS*FIELD_W-1:0]),
  .syncEn(syncEn), .syncRst(syncRst), .busy(busy), .done(done)
);

// File: tb/phy_sync_sequencer_bench.sv
module phy_sync_sequencer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        syncEn, syncRst, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  phy_sync_sequencer u_phy_sync_sequencer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .syncEn(syncEn), .syncRst(syncRst), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] packCfg(input int en, input int gap, input int rs,
                                          input int st, input bit start);
    return {start, 15'h2A5C, 4'(st), 4'(en), 4'(gap), 4'(rs)};
  endfunction

  // start a run and compare every output in every cycle against the schedule;
  // intrude>=0 writes junk in that cycle of the run
  task automatic runSeq(input int en, input int gap, input int rs, input int st,
                        input string req, input int intrude);
    int total = en + gap + rs + st + 8;
    int bad = 0;
    logic [4:0] act, exp;
    logic [4:0] firstAct = '0, firstExp = '0;
    @(negedge clk);
    wrEn = 1'b1; wrData = packCfg(en, gap, rs, st, 1'b1);
    @(negedge clk);
    wrEn = 1'b0;
    for (int i = 0; i <= total; i++) begin
      exp = {i < en,
             (i >= en + gap) && (i < en + gap + rs),
             i < total,
             i == total,
             i < total};
      act = {syncEn, syncRst, busy, done, rdData[31]};
      if (act !== exp && bad == 0) begin firstAct = act; firstExp = exp; end
      if (act !== exp) bad++;
      if (i == intrude) begin
        wrEn = 1'b1; wrData = (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
      end else begin
        wrEn = 1'b0;
      end
      if (i < total) @(negedge clk);
    end
    wrEn = 1'b0;
    check(bad == 0, req, $sformatf("schedule en=%0d gap=%0d rst=%0d st=%0d {en,rst,busy,done,b31}",
          en, gap, rs, st), firstAct, firstExp);
    check(rdData == packCfg(en, gap, rs, st, 1'b0), req, "readback after run",
          rdData, packCfg(en, gap, rs, st, 1'b0));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base[4];
    string tags[4];
    repeat (3) @(negedge clk);
    check(rdData == 0, "R1", "rdData in reset", rdData, 0);
    check({syncEn, syncRst, busy, done} == 0, "R1", "outputs in reset",
          {syncEn, syncRst, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 0 && !busy, "R1", "after reset release", rdData, 0);

    // R2: store without start
    wrEn = 1'b1; wrData = 32'h7654_ABCD;
    @(negedge clk);
    wrEn = 1'b0;
    check(rdData == 32'h7654_ABCD, "R2", "plain store readback", rdData, 32'h7654_ABCD);
    begin
      int act = 0;
      for (int i = 0; i < 20; i++) begin
        if (busy || syncEn || syncRst || done) act++;
        @(negedge clk);
      end
      check(act == 0, "R2", "no run without start bit", act, 0);
    end

    // R6: all zero, then single zero phases
    runSeq(0, 0, 0, 0, "R6", -1);
    runSeq(0, 3, 2, 1, "R6", -1);
    runSeq(4, 0, 0, 2, "R6", -1);
    runSeq(15, 15, 15, 15, "R5", -1);

    // sweep every value of each field with the others fixed
    base = '{3, 2, 1, 5};
    tags = '{"R3", "R4", "R4", "R5"};
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 16; v++) begin
        int p[4];
        p = base;
        p[f] = v;
        runSeq(p[0], p[1], p[2], p[3], (v == 0) ? "R6" : tags[f], -1);
      end
    end

    // R7: writes during a run change nothing
    runSeq(5, 4, 3, 2, "R7", 1);
    runSeq(5, 4, 3, 2, "R7", 6);
    runSeq(2, 1, 6, 0, "R7", 9);

    // R8: back-to-back restart and done width
    runSeq(1, 1, 1, 1, "R8", -1);
    @(negedge clk);
    check(!done && !busy, "R8", "done lasts one cycle", {done, busy}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule